// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises a processor that must prove it is alive by rewriting a configuration word before a countdown runs out. It starts counting straight out of reset with conservative defaults. When the countdown first reaches zero it warns the system with a one-cycle non-maskable interrupt pulse. It then starts a second, separately programmed grace countdown. If software rewrites the configuration word during that grace period, the warning is forgotten and normal supervision resumes. If it does not, the block emits a one-cycle system reset request and latches an error code. The sequencing of the system reset is left to the surrounding logic.

A single write carries three fields: the grace delay, the prescaler divisor and the main count. A separate one-shot disable strobe lets boot code switch the watchdog off for good. The strobe works only while the block is still in its power-up state, before the first configuration write. Once disabled, the block stops at its next prescaler tick and stays stopped until a configuration write restarts it.

Top module: `twostage_wdog`

## Requirements
- R1: After rst_n the state output is 0 (power-up). Interrupt and reset outputs are low and the error code is 0. The block counts at once with divisor 255, grace delay 255 and main count 0xFFFF.
- R2: One prescaler tick occurs every divisor+1 clock cycles. A divisor of 0 ticks on every cycle. On a tick in state 0 or 2, a non-zero counter decrements by one.
- R3: A tick in state 0 or 2 with the counter at zero and no warning pending does three things: it gives a one-cycle nmi_o pulse in the next cycle, loads the counter with the grace delay, and marks the warning as pending.
- R4: A tick in state 0 or 2 with the counter at zero and a warning pending gives a one-cycle sys_rst_o pulse in the next cycle. It also sets err_code_o to 0xC000 in that same cycle, and the code is held until rst_n.
- R5: A configuration write (cfg_wr) takes the grace delay from wr_data[31:24], the divisor from wr_data[23:16] and the main count from wr_data[15:0]. It clears any pending warning, puts the block in state 2 (enabled) and restarts the prescaler from the new divisor. It also suppresses any expiry in the same cycle.
- R6: A disable strobe (trap_wr) in state 0 moves the block to state 1 (disabled). In state 1 the counter does not count and no pulse is produced. The next prescaler tick moves the block to state 3 (stopped).
- R7: A disable strobe in state 1, 2 or 3 has no effect.
- R8: When cfg_wr and trap_wr are both high in the same cycle, the configuration write is taken and the strobe is ignored, even in state 0.
- R9: In the cycle of a sys_rst_o pulse the block is back in state 0 with the R1 defaults reloaded. Only the error code keeps its value.
- R10: In state 3 nothing changes and no tick occurs until a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration write strobe |
| trap_wr | input | 1 | One-shot disable strobe |
| wr_data | input | 32 | Configuration word: delay, divisor, count |
| nmi_o | output | 1 | One-cycle first-expiry interrupt pulse |
| sys_rst_o | output | 1 | One-cycle system reset request |
| err_code_o | output | 16 | Error status, 0xC000 after a watchdog reset |
| state_o | output | 2 | 0 power-up, 1 disabled, 2 enabled, 3 stopped |

## Verification
The assertions check on every cycle that both pulses last exactly one cycle and that the error code changes only together with a reset pulse. They also check that the disabled state can only be entered from power-up through a strobe, that stopped can only follow disabled, and that a configuration write always lands in the enabled state with no pulse. The timing of the two expiries for given divisor, count and delay values can only be shown by the bench's scenarios. The same holds for the clearing of a pending warning by a service write and for the effect of the defaults. The bench therefore times each pulse against its expected cycle and compares every output with a behavioural model on each clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_INIT = 2'd0,
    WD_OFF  = 2'd1,
    WD_RUN  = 2'd2,
    WD_HALT = 2'd3
  } wd_state_e;

  localparam int ERR_W = 16;
  localparam logic [ERR_W-1:0] WD_RESET_CODE = 16'hC000;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int              SCL_W   = 8,
  parameter logic [SCL_W-1:0] SCL_DEF = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             restore,
  input  logic             run,
  input  logic [SCL_W-1:0] scale_in,
  output logic             tick
);
  logic [SCL_W-1:0] scale_q, scale_d;
  logic [SCL_W-1:0] pre_q, pre_d;
  logic             pre_zero;

  assign pre_zero = (pre_q == '0);
  assign tick     = run && pre_zero;

  always_comb begin
    scale_d = scale_q;
    pre_d   = pre_q;
    if (load) begin
      scale_d = scale_in;
      pre_d   = scale_in;
    end else if (restore) begin
      scale_d = SCL_DEF;
      pre_d   = SCL_DEF;
    end else if (run) begin
      pre_d = pre_zero ? scale_q : (pre_q - SCL_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= SCL_DEF;
      pre_q   <= SCL_DEF;
    end else begin
      scale_q <= scale_d;
      pre_q   <= pre_d;
    end
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int               CNT_W   = 16,
  parameter int               DLY_W   = 8,
  parameter logic [CNT_W-1:0] CNT_DEF = '1,
  parameter logic [DLY_W-1:0] DLY_DEF = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [DLY_W-1:0] dly_in,
  input  logic             tick,
  input  logic             live,
  output logic             nmi_evt,
  output logic             rst_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             pend_q, pend_d;
  logic             step, expire;

  assign step    = tick && live && !load;
  assign expire  = step && (cnt_q == '0);
  assign nmi_evt = expire && !pend_q;
  assign rst_evt = expire && pend_q;

  always_comb begin
    cnt_d  = cnt_q;
    dly_d  = dly_q;
    pend_d = pend_q;
    if (load) begin
      cnt_d  = cnt_in;
      dly_d  = dly_in;
      pend_d = 1'b0;
    end else if (rst_evt) begin
      cnt_d  = CNT_DEF;
      dly_d  = DLY_DEF;
      pend_d = 1'b0;
    end else if (nmi_evt) begin
      cnt_d  = CNT_W'(dly_q);
      pend_d = 1'b1;
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_DEF;
      dly_q  <= DLY_DEF;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dly_q  <= dly_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  logic      trap_wr,
  input  logic      tick,
  input  logic      restore,
  output wd_state_e state,
  output logic      live,
  output logic      run
);
  wd_state_e state_d;

  assign live = (state == WD_INIT) || (state == WD_RUN);
  assign run  = (state != WD_HALT);

  always_comb begin
    state_d = state;
    if (cfg_wr) begin
      state_d = WD_RUN;
    end else if (restore) begin
      state_d = WD_INIT;
    end else if (trap_wr && (state == WD_INIT)) begin
      state_d = WD_OFF;
    end else if (tick && (state == WD_OFF)) begin
      state_d = WD_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WD_INIT;
    else        state <= state_d;
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SCL_W     = 8,
  parameter int DLY_W     = 8,
  parameter int DEF_COUNT = 65535,
  parameter int DEF_SCALE = 255,
  parameter int DEF_DELAY = 255,
  localparam int DATA_W   = DLY_W + SCL_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              trap_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              nmi_o,
  output logic              sys_rst_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic [1:0]        state_o
);
  localparam int SCL_LSB = CNT_W;
  localparam int DLY_LSB = CNT_W + SCL_W;

  logic [CNT_W-1:0] f_cnt;
  logic [SCL_W-1:0] f_scl;
  logic [DLY_W-1:0] f_dly;
  logic             tick, live, run, nmi_evt, rst_evt;
  wd_state_e        state;

  logic             nmi_q, nmi_d, rst_q, rst_d;
  logic [ERR_W-1:0] err_q, err_d;

  assign f_cnt = wr_data[0 +: CNT_W];
  assign f_scl = wr_data[SCL_LSB +: SCL_W];
  assign f_dly = wr_data[DLY_LSB +: DLY_W];

  wdt_prescale #(
    .SCL_W   (SCL_W),
    .SCL_DEF (SCL_W'(DEF_SCALE))
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_wr),
    .restore  (rst_evt),
    .run      (run),
    .scale_in (f_scl),
    .tick     (tick)
  );

  wdt_count #(
    .CNT_W   (CNT_W),
    .DLY_W   (DLY_W),
    .CNT_DEF (CNT_W'(DEF_COUNT)),
    .DLY_DEF (DLY_W'(DEF_DELAY))
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_wr),
    .cnt_in  (f_cnt),
    .dly_in  (f_dly),
    .tick    (tick),
    .live    (live),
    .nmi_evt (nmi_evt),
    .rst_evt (rst_evt)
  );

  wdt_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .trap_wr (trap_wr),
    .tick    (tick),
    .restore (rst_evt),
    .state   (state),
    .live    (live),
    .run     (run)
  );

  always_comb begin
    nmi_d = nmi_evt;
    rst_d = rst_evt;
    err_d = rst_evt ? WD_RESET_CODE : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
      err_q <= '0;
    end else begin
      nmi_q <= nmi_d;
      rst_q <= rst_d;
      err_q <= err_d;
    end
  end

  assign nmi_o      = nmi_q;
  assign sys_rst_o  = rst_q;
  assign err_code_o = err_q;
  assign state_o    = state;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        trap_wr,
  input logic        nmi_o,
  input logic        sys_rst_o,
  input logic [15:0] err_code_o,
  input logic [1:0]  state_o
);
  localparam logic [1:0] S_INIT = 2'd0;
  localparam logic [1:0] S_OFF  = 2'd1;
  localparam logic [1:0] S_RUN  = 2'd2;
  localparam logic [1:0] S_HALT = 2'd3;

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) nmi_o |=> !nmi_o); // R3
  AST_NMI_LIVE: assert property (@(posedge clk) disable iff (!rst_n) nmi_o |-> (state_o == S_INIT || state_o == S_RUN)); // R3
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_o |=> !sys_rst_o); // R4
  AST_RST_CODE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_o |-> err_code_o == 16'hC000); // R4
  AST_ERR_MOVES_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n) (err_code_o != $past(err_code_o)) |-> sys_rst_o); // R4
  AST_CFG_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) $past(cfg_wr && rst_n) |-> (state_o == S_RUN && !nmi_o && !sys_rst_o)); // R5
  AST_OFF_FROM_INIT: assert property (@(posedge clk) disable iff (!rst_n) (state_o == S_OFF && $past(state_o) != S_OFF) |-> ($past(state_o) == S_INIT && $past(trap_wr))); // R6
  AST_HALT_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n) (state_o == S_HALT && $past(state_o) != S_HALT) |-> $past(state_o) == S_OFF); // R6
  AST_TRAP_LATE: assert property (@(posedge clk) disable iff (!rst_n) $past(trap_wr && !cfg_wr && state_o == S_RUN) |-> state_o != S_OFF); // R7
  AST_RST_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_o |-> state_o == S_INIT); // R9
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) $past(state_o == S_HALT && !cfg_wr) |-> (state_o == S_HALT && !nmi_o && !sys_rst_o)); // R10
endmodule

bind twostage_wdog wdt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .trap_wr    (trap_wr),
  .nmi_o      (nmi_o),
  .sys_rst_o  (sys_rst_o),
  .err_code_o (err_code_o),
  .state_o    (state_o)
);

// File: tb/twostage_wdog_tb_top.sv
module twostage_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        trap_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        nmi_o, sys_rst_o;
  logic [15:0] err_code_o;
  logic [1:0]  state_o;

  int checks = 0;
  int fails  = 0;
  int wd_cnt = 0;

  always #10 clk = ~clk;

  twostage_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .trap_wr(trap_wr), .wr_data(wr_data),
    .nmi_o(nmi_o), .sys_rst_o(sys_rst_o), .err_code_o(err_code_o), .state_o(state_o)
  );

  // behavioural reference model
  int m_state, m_pre, m_scale, m_cnt, m_dly, m_pend, m_nmi, m_rst, m_err;

  task automatic model_defaults();
    m_state = 0; m_pre = 255; m_scale = 255; m_cnt = 65535; m_dly = 255; m_pend = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_defaults();
      m_nmi = 0; m_rst = 0; m_err = 0;
    end else begin
      bit tk, lv, restored;
      tk = (m_state != 3) && (m_pre == 0);
      lv = (m_state == 0) || (m_state == 2);
      restored = 0;
      m_nmi = 0; m_rst = 0;
      if (cfg_wr) begin
        m_dly = wr_data[31:24]; m_scale = wr_data[23:16]; m_cnt = wr_data[15:0];
        m_pre = m_scale; m_pend = 0; m_state = 2;
      end else begin
        if (m_state != 3) m_pre = (m_pre == 0) ? m_scale : m_pre - 1;
        if (tk && lv) begin
          if (m_cnt != 0) m_cnt = m_cnt - 1;
          else if (m_pend != 0) begin
            model_defaults(); m_rst = 1; m_err = 'hC000; restored = 1;
          end else begin
            m_nmi = 1; m_cnt = m_dly; m_pend = 1;
          end
        end
        if (!restored) begin
          if (trap_wr && m_state == 0) m_state = 1;
          else if (tk && m_state == 1) m_state = 3;
        end
      end
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check_eq("R3 model nmi_o", int'(nmi_o), m_nmi);
      check_eq("R4 model sys_rst_o", int'(sys_rst_o), m_rst);
      check_eq("R4 model err_code_o", int'(err_code_o), m_err);
      check_eq("R6 model state_o", int'(state_o), m_state);
    end
  end

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", wd_cnt);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic write_cfg(int d, int s, int c, bit trap);
    cfg_wr = 1'b1; trap_wr = trap;
    wr_data = {8'(d), 8'(s), 16'(c)};
    @(negedge clk);
    cfg_wr = 1'b0; trap_wr = 1'b0;
  endtask

  task automatic do_trap();
    trap_wr = 1'b1;
    @(negedge clk);
    trap_wr = 1'b0;
  endtask

  // sel: 0 nmi_o, 1 sys_rst_o, 2 state_o==3
  task automatic pulse_after(int sel, int n, string tag);
    int hit = 0;
    for (int i = 1; i <= n + 4 && hit == 0; i++) begin
      bit s;
      @(negedge clk);
      s = (sel == 0) ? nmi_o : (sel == 1) ? sys_rst_o : (state_o == 2'd3);
      if (s) hit = i;
    end
    check_eq(tag, hit, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_eq("R1 state after reset", int'(state_o), 0);
    check_eq("R1 nmi after reset", int'(nmi_o), 0);
    check_eq("R1 err after reset", int'(err_code_o), 0);
    // R6 disable strobe in power-up, stop at first tick (default divisor 255, R1)
    do_trap();
    check_eq("R6 disabled state", int'(state_o), 1);
    pulse_after(2, 255, "R1 R6 stop at default tick");
    repeat (20) @(negedge clk);
    check_eq("R10 stopped stays", int'(state_o), 3);
    // R5 restart from stopped; R3/R4 timing
    write_cfg(1, 3, 2, 1'b0);
    check_eq("R5 enabled after write", int'(state_o), 2);
    pulse_after(0, 12, "R3 first expiry timing");
    pulse_after(1, 8, "R4 second expiry timing");
    check_eq("R4 error code", int'(err_code_o), 'hC000);
    check_eq("R9 back to power-up", int'(state_o), 0);
    // R7 late strobe ignored
    write_cfg(5, 1, 3, 1'b0);
    do_trap();
    check_eq("R7 late strobe ignored", int'(state_o), 2);
    pulse_after(0, 7, "R7 still counting");
    // R5 service clears pending warning
    write_cfg(5, 1, 3, 1'b0);
    pulse_after(0, 8, "R5 service gives fresh nmi");
    // R2 divisor 0 boundary
    write_cfg(0, 0, 0, 1'b0);
    pulse_after(0, 1, "R2 divisor zero nmi");
    pulse_after(1, 1, "R2 divisor zero reset");
    check_eq("R9 power-up after reset", int'(state_o), 0);
    // R8 simultaneous write and strobe
    write_cfg(0, 2, 1, 1'b1);
    check_eq("R8 write wins over strobe", int'(state_o), 2);
    pulse_after(0, 6, "R8 counting after write");
    check_eq("R4 error code held", int'(err_code_o), 'hC000);
    // R1 reset clears error code
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1 err cleared by rst_n", int'(err_code_o), 0);
    check_eq("R1 state power-up", int'(state_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule